// File: doc/BRIEF.md
# PCI First-Error Capture Unit

This block keeps a diagnostic snapshot of the first failure reported on a PCI bus interface. Upstream logic has already decided that a transaction failed and raises a one-cycle error pulse. In that cycle the block is also given the transaction's address, its transfer type, its bus command code and the number of the master that owned the bus. The block stores these values and then ignores any further errors. Software later reads the record through a small select-addressed register port.

A valid flag shows whether a record is held. Software writes 1 to that flag to release the record, and the next error pulse is then captured. The captured fields keep their old contents until that next capture replaces them. The master number is stored only while the controller is bus host. Outside host mode a capture writes zero into that field. An active-low power-on reset returns every field and the flag to zero.

Top module: `pci_first_err_cap`

## Requirements
- R1: After reset, the valid flag is 0 and all four register selections (0..3) read zero.
- R2: An error pulse while the flag is 0 sets the flag on the next clock edge. From then on, selection 1 returns the transaction address, zero-extended.
- R3: The same capture stores the command code in selection 2 bits [CMD_W-1:0] and the transfer type in the bits directly above it. All higher bits read zero.
- R4: When host mode is high at capture, selection 3 returns the bus master number in its low bits.
- R5: When host mode is low at capture, selection 3 reads zero, whatever master number was presented.
- R6: While the flag is 1 and no clear is written, further error pulses change neither the flag nor any captured field.
- R7: Writing selection 0 with bit 0 set clears the flag on the next edge. The captured fields keep their previous values until a new capture.
- R8: Writing selection 0 with bit 0 clear has no effect, and neither does any write to selections 1, 2 or 3.
- R9: An error pulse in the same cycle as a clearing write is captured. The flag stays 1 and the fields take the new values.
- R10: Asserting reset after a capture returns the flag and every field to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| host_mode | input | 1 | High while the controller is the bus host |
| err_pulse | input | 1 | One-cycle decoded error indication |
| txn_addr | input | ADDR_W | Address of the current transaction |
| txn_type | input | TYPE_W | Transfer type of the current transaction |
| txn_cmd | input | CMD_W | Bus command code of the current transaction |
| txn_master | input | MASTER_W | Number of the master that owns the bus |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register selection: 0 flag, 1 address, 2 type/command, 3 master |
| csr_wdata | input | DATA_W | Write data; only bit 0 of selection 0 acts |
| csr_rdata | output | DATA_W | Read data for the current selection (combinational) |
| err_valid | output | 1 | A record is held |

## Verification
The assertions assume three things about the inputs. First, the transaction attributes are valid in the cycle the error pulse is high. Second, host mode does not change in the middle of that cycle. Third, the write strobe and selection change only between clock edges.

The bench drives every input just after the falling edge and holds it steady through the rising edge. It sweeps every command code and transfer type in both host and non-host mode. Each time, it releases the record, captures one error, fires a second, different error, and makes writes that should have no effect, so the first-error rule is exercised in both modes.

// File: rtl/fec_pkg.sv
package fec_pkg;
   typedef enum logic [1:0] {
      SEL_FLAG   = 2'd0,
      SEL_ADDR   = 2'd1,
      SEL_CMD    = 2'd2,
      SEL_MASTER = 2'd3
   } fec_sel_e;
endpackage

// File: rtl/fec_record.sv
module fec_record #(
   parameter int ADDR_W     = 32,
   parameter int TYPE_W     = 2,
   parameter int CMD_W      = 4,
   parameter int MASTER_W   = 3,
   parameter bit HAS_MASTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                err_i,
   input  logic                clr_i,
   input  logic                host_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [TYPE_W-1:0]   type_i,
   input  logic [CMD_W-1:0]    cmd_i,
   input  logic [MASTER_W-1:0] master_i,
   output logic                valid_o,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [TYPE_W-1:0]   type_o,
   output logic [CMD_W-1:0]    cmd_o,
   output logic [MASTER_W-1:0] master_o
);
   logic valid_q;
   logic take;

   // A record is taken when none is held, or when software releases the
   // current one in the same cycle as the new error.
   assign take = err_i && (!valid_q || clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_o  <= '0;
         type_o  <= '0;
         cmd_o   <= '0;
      end else begin
         if (take) begin
            valid_q <= 1'b1;
            addr_o  <= addr_i;
            type_o  <= type_i;
            cmd_o   <= cmd_i;
         end else if (clr_i) begin
            valid_q <= 1'b0;
         end
      end
   end

   generate
      if (HAS_MASTER) begin : g_master
         logic [MASTER_W-1:0] master_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    master_q <= '0;
            else if (take) master_q <= host_i ? master_i : '0;
         end
         assign master_o = master_q;
      end else begin : g_no_master
         assign master_o = '0;
      end
   endgenerate

   assign valid_o = valid_q;

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && !valid_q) |=> (valid_q && addr_o == $past(addr_i)));

   assert_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && !valid_q) |=> (cmd_o == $past(cmd_i) && type_o == $past(type_i)));

   assert_nohost_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && (!valid_q || clr_i) && !host_i) |=> (master_o == '0));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !clr_i) |=> (valid_q && $stable(addr_o) && $stable(type_o)
                               && $stable(cmd_o) && $stable(master_o)));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !err_i) |=> (!valid_q && $stable(addr_o)));

   assert_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && err_i) |=> (valid_q && addr_o == $past(addr_i)));
endmodule

// File: rtl/fec_csr.sv
module fec_csr
   import fec_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int TYPE_W   = 2,
   parameter int CMD_W    = 4,
   parameter int MASTER_W = 3
) (
   input  logic                wr_i,
   input  logic [1:0]          sel_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic                valid_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [TYPE_W-1:0]   type_i,
   input  logic [CMD_W-1:0]    cmd_i,
   input  logic [MASTER_W-1:0] master_i,
   output logic                clr_o,
   output logic [DATA_W-1:0]   rdata_o
);
   localparam int CT_W = TYPE_W + CMD_W;

   fec_sel_e sel;
   logic [CT_W-1:0] cmd_word;

   assign sel      = fec_sel_e'(sel_i);
   assign cmd_word = {type_i, cmd_i};

   // Only the flag bit is writable; it is write-one-to-clear.
   assign clr_o = wr_i && (sel == SEL_FLAG) && wdata_i[0];

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_FLAG:   rdata_o[0]          = valid_i;
         SEL_ADDR:   rdata_o[ADDR_W-1:0] = addr_i;
         SEL_CMD:    rdata_o[CT_W-1:0]   = cmd_word;
         SEL_MASTER: rdata_o[MASTER_W-1:0] = master_i;
         default:    rdata_o = '0;
      endcase
   end

   always_comb begin
      assert_flag_only_R8: assert (!clr_o || (wr_i && sel_i == 2'd0));
   end
endmodule

// File: rtl/pci_first_err_cap.sv
module pci_first_err_cap #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int TYPE_W     = 2,
   parameter int CMD_W      = 4,
   parameter int MASTER_W   = 3,
   parameter bit HAS_MASTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_mode,
   input  logic                err_pulse,
   input  logic [ADDR_W-1:0]   txn_addr,
   input  logic [TYPE_W-1:0]   txn_type,
   input  logic [CMD_W-1:0]    txn_cmd,
   input  logic [MASTER_W-1:0] txn_master,
   input  logic                csr_wr,
   input  logic [1:0]          csr_sel,
   input  logic [DATA_W-1:0]   csr_wdata,
   output logic [DATA_W-1:0]   csr_rdata,
   output logic                err_valid
);
   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..DATA_W");
      end
      if (TYPE_W < 1 || CMD_W < 1 || TYPE_W + CMD_W > DATA_W) begin : g_bad_cmd
         $error("TYPE_W + CMD_W must fit in DATA_W");
      end
      if (MASTER_W < 1 || MASTER_W > DATA_W) begin : g_bad_master
         $error("MASTER_W must lie in 1..DATA_W");
      end
   endgenerate

   logic                clr;
   logic                valid;
   logic [ADDR_W-1:0]   rec_addr;
   logic [TYPE_W-1:0]   rec_type;
   logic [CMD_W-1:0]    rec_cmd;
   logic [MASTER_W-1:0] rec_master;

   fec_csr #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W),
      .CMD_W(CMD_W), .MASTER_W(MASTER_W)
   ) u_csr (
      .wr_i(csr_wr), .sel_i(csr_sel), .wdata_i(csr_wdata),
      .valid_i(valid), .addr_i(rec_addr), .type_i(rec_type),
      .cmd_i(rec_cmd), .master_i(rec_master),
      .clr_o(clr), .rdata_o(csr_rdata)
   );

   fec_record #(
      .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .CMD_W(CMD_W),
      .MASTER_W(MASTER_W), .HAS_MASTER(HAS_MASTER)
   ) u_rec (
      .clk(clk), .rst_n(rst_n), .err_i(err_pulse), .clr_i(clr),
      .host_i(host_mode), .addr_i(txn_addr), .type_i(txn_type),
      .cmd_i(txn_cmd), .master_i(txn_master),
      .valid_o(valid), .addr_o(rec_addr), .type_o(rec_type),
      .cmd_o(rec_cmd), .master_o(rec_master)
   );

   assign err_valid = valid;

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!err_valid || $past(err_pulse)));
endmodule

// File: tb/sim_pci_first_err_cap.sv
module sim_pci_first_err_cap;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_mode = 1'b0;
   logic        err_pulse = 1'b0;
   logic [31:0] txn_addr = '0;
   logic [1:0]  txn_type = '0;
   logic [3:0]  txn_cmd = '0;
   logic [2:0]  txn_master = '0;
   logic        csr_wr = 1'b0;
   logic [1:0]  csr_sel = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        err_valid;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [31:0] e_addr, e_cmd, e_mst;

   pci_first_err_cap u0 (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .err_pulse(err_pulse),
      .txn_addr(txn_addr), .txn_type(txn_type), .txn_cmd(txn_cmd),
      .txn_master(txn_master), .csr_wr(csr_wr), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .err_valid(err_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      csr_sel = s;
      #1;
      v = csr_rdata;
   endtask

   // Drive lands after a falling edge; one rising edge; back to a falling edge.
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      err_pulse = 1'b0;
      csr_wr    = 1'b0;
   endtask

   task automatic check_record(input string req, input logic vexp);
      logic [31:0] v;
      chk({req, " flag"}, {31'd0, err_valid}, {31'd0, vexp});
      rd(2'd0, v); chk({req, " sel0"}, v, {31'd0, vexp});
      rd(2'd1, v); chk({req, " sel1"}, v, e_addr);
      rd(2'd2, v); chk({req, " sel2"}, v, e_cmd);
      rd(2'd3, v); chk({req, " sel3"}, v, e_mst);
   endtask

   task automatic strobe(input logic h, input logic [31:0] a, input logic [1:0] t,
                         input logic [3:0] c, input logic [2:0] m);
      host_mode = h; txn_addr = a; txn_type = t; txn_cmd = c; txn_master = m;
      err_pulse = 1'b1;
   endtask

   task automatic csr_write(input logic [1:0] s, input logic [31:0] d);
      csr_wr = 1'b1; csr_sel = s; csr_wdata = d;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      e_addr = 0; e_cmd = 0; e_mst = 0;
      @(negedge clk); @(negedge clk);
      check_record("R1 reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_record("R1 after release", 1'b0);

      for (int i = 0; i < 128; i++) begin
         logic        h;
         logic [1:0]  t;
         logic [3:0]  c;
         logic [2:0]  m;
         logic [31:0] a;
         h = i[6];
         t = i[5:4];
         c = i[3:0];
         m = 3'(i * 5 + 3);
         a = 32'h1000_0000 + 32'(i) * 32'h0101_0104;

         // R7: release, fields retained
         csr_write(2'd0, 32'h1);
         tick();
         check_record("R7 clear", 1'b0);

         // R2/R3/R4/R5: capture
         strobe(h, a, t, c, m);
         tick();
         e_addr = a;
         e_cmd  = {26'd0, t, c};
         e_mst  = h ? {29'd0, m} : 32'd0;
         check_record(h ? "R2 R3 R4 capture" : "R2 R3 R5 capture", 1'b1);

         // R6: second error ignored
         strobe(~h, ~a, ~t, ~c, ~m);
         tick();
         check_record("R6 second error", 1'b1);

         // R8: ineffective writes
         csr_write(2'd0, 32'hFFFF_FFFE);
         tick();
         csr_write(2'd1, 32'hFFFF_FFFF);
         tick();
         csr_write(2'd2, 32'hFFFF_FFFF);
         tick();
         csr_write(2'd3, 32'hFFFF_FFFF);
         tick();
         check_record("R8 ignored writes", 1'b1);
      end

      // R9: error in the same cycle as clear
      csr_write(2'd0, 32'h1);
      strobe(1'b1, 32'hDEAD_BEEF, 2'd2, 4'hA, 3'd6);
      tick();
      e_addr = 32'hDEAD_BEEF; e_cmd = 32'h2A; e_mst = 32'd6;
      check_record("R9 race", 1'b1);

      // R10: reset after capture
      rst_n = 1'b0;
      #1;
      e_addr = 0; e_cmd = 0; e_mst = 0;
      check_record("R10 reset", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_record("R10 after reset", 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule